// File: doc/BRIEF.md
# Display Driver Bring-Up Sequencer

This block is the host-side controller that wakes a display driver chip and takes charge of it. After power-on it holds the chip's reset line active. A `start` pulse releases that line and waits out a settle period counted in system clocks. The sequencer then runs a fixed series of register accesses over a request/acknowledge port. It writes a known pattern and reads it back to prove the link. It reads the identity register and splits it into an ID and a revision nibble. It reads the resolution code and checks it against the supported set. Last, it reads the control register, sets the software-ownership bit and writes the value back.

Once bring-up succeeds, `done` stays high. Two single-cycle commands, `en_cmd` and `dis_cmd`, then switch the panel's power bit on or off by read-modify-write of the control register. If the link test or the resolution check fails, the sequencer raises a sticky error flag, stops issuing accesses and ignores commands until reset. The serial framing of the accesses is left to the responder on the other side of the port.

Top module: `panel_bringup_seq`

## Requirements
- R1: After reset, `chip_rst` is 1 and `req_valid`, `done`, `err_nodev` and `err_mode` are all 0.
- R2: A `start` pulse in the idle state drives `chip_rst` to 0. `req_valid` first rises exactly `SETTLE_CYC` clock cycles after `chip_rst` falls, and never while `chip_rst` is 1.
- R3: The first two accesses are a write of 0x55 to address 0 and then a read of address 0. If that read returns anything other than 0x55, `err_nodev` is set and no further access is issued.
- R4: The third access reads address 1. Bits 7:4 of the data appear on `chip_id` and bits 3:0 on `chip_ver`.
- R5: The fourth access reads address 2. Its bits 2:0 form the resolution code, and higher bits are ignored. Code 1 is reported as code 5 on `mode_code`.
- R6: A resolution code of 2 or 3 sets `err_mode` and stops the sequence. Codes 0, 4, 5, 6 and 7 are accepted.
- R7: After an accepted code, the sequencer reads address 3 and writes back the read value with bit 7 set. `done` rises once that write is acknowledged and stays high until reset. At most one of `done`, `err_nodev` and `err_mode` is ever high.
- R8: When `done` is high and no access is pending, `en_cmd` reads address 3 and writes it back with bit 0 set. `dis_cmd` does the same with bit 0 cleared. If both are given in the same cycle, `en_cmd` wins.
- R9: `en_cmd` and `dis_cmd` cause no access before bring-up completes or after an error. `start` is ignored outside the idle state.
- R10: A request holds `req_valid`, `req_write`, `req_addr` and `req_wdata` stable until `ack` is seen. Only one access is outstanding at a time, and any number of wait cycles before `ack` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins bring-up from idle |
| en_cmd | input | 1 | Pulse: set the panel power bit |
| dis_cmd | input | 1 | Pulse: clear the panel power bit |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| ack | input | 1 | One-cycle completion of the pending access |
| ack_rdata | input | DATA_W | Read data, valid with `ack` |
| chip_rst | output | 1 | Reset to the display chip, 1 = held in reset |
| done | output | 1 | Bring-up completed successfully |
| err_nodev | output | 1 | Link test failed |
| err_mode | output | 1 | Unsupported resolution code |
| mode_code | output | MODE_W | Detected resolution code after folding |
| chip_id | output | 4 | Upper nibble of the identity register |
| chip_ver | output | 4 | Lower nibble of the identity register |

## Verification
The hardest situations to reach are the ones after an error and the commands that come after bring-up. Each needs a full detect sequence first, with a responder that answers in a particular way. The bench's responder model holds a small register file and can corrupt the link-test read-back or present any resolution code with noise in the upper bits. It can also stretch every acknowledge by a chosen number of wait cycles. Each scenario runs the whole sequence against a queue of the accesses the requirements predict. Commands are then pulsed in states where they must be ignored, and the bench checks that no access appears.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETTLE,
    S_WR_TEST,
    S_RD_TEST,
    S_RD_ID,
    S_RD_MODE,
    S_RD_CTRL,
    S_WR_CTRL,
    S_READY,
    S_CMD_RD,
    S_CMD_WR,
    S_FAIL
  } seq_state_e;

  // Register addresses seen by the display chip
  localparam int unsigned REG_TEST = 0;
  localparam int unsigned REG_ID   = 1;
  localparam int unsigned REG_MODE = 2;
  localparam int unsigned REG_CTRL = 3;

  localparam int unsigned LINK_PATTERN = 8'h55;
  localparam int unsigned BIT_SWCTRL   = 7;
  localparam int unsigned BIT_POWER    = 0;
  localparam int unsigned NIB_W        = 4;

endpackage

// File: rtl/pbs_settle_timer.sv
module pbs_settle_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? CW'(CYCLES - 1) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pbs_mode_decode.sv
module pbs_mode_decode #(
  parameter int unsigned        CODE_W    = 3,
  parameter int unsigned        FOLD_FROM = 1,
  parameter int unsigned        FOLD_TO   = 5,
  parameter logic [2**CODE_W-1:0] ACCEPT  = 8'b1111_0001
) (
  input  logic [CODE_W-1:0] raw,
  output logic [CODE_W-1:0] folded,
  output logic              supported
);
  always_comb begin
    folded    = (raw == CODE_W'(FOLD_FROM)) ? CODE_W'(FOLD_TO) : raw;
    supported = ACCEPT[folded];
  end
endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq
  import pbs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MODE_W     = 3,
  parameter int unsigned SETTLE_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] ack_rdata,
  output logic              chip_rst,
  output logic              done,
  output logic              err_nodev,
  output logic              err_mode,
  output logic [MODE_W-1:0] mode_code,
  output logic [3:0]        chip_id,
  output logic [3:0]        chip_ver
);
  localparam logic [DATA_W-1:0] SW_MASK  = DATA_W'(1) << BIT_SWCTRL;
  localparam logic [DATA_W-1:0] PWR_MASK = DATA_W'(1) << BIT_POWER;

  seq_state_e state_q, state_d;

  logic [DATA_W-1:0] shadow_q;
  logic              cmd_set_q;
  logic              rst_q, done_q, nodev_q, moderr_q;
  logic [MODE_W-1:0] mode_q;
  logic [NIB_W-1:0]  id_q, ver_q;

  // Clock enables and set strobes from the next-state logic
  logic tmr_load, tmr_expired;
  logic rel_rst, set_done, set_nodev, set_moderr;
  logic cap_shadow, cap_id, cap_mode, cap_cmd;

  logic [MODE_W-1:0] mode_folded;
  logic              mode_ok;

  pbs_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  pbs_mode_decode #(.CODE_W(MODE_W)) u_decode (
    .raw       (ack_rdata[MODE_W-1:0]),
    .folded    (mode_folded),
    .supported (mode_ok)
  );

  // Next-state process
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    rel_rst    = 1'b0;
    set_done   = 1'b0;
    set_nodev  = 1'b0;
    set_moderr = 1'b0;
    cap_shadow = 1'b0;
    cap_id     = 1'b0;
    cap_mode   = 1'b0;
    cap_cmd    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d  = S_SETTLE;
        tmr_load = 1'b1;
        rel_rst  = 1'b1;
      end
      S_SETTLE:  if (tmr_expired) state_d = S_WR_TEST;
      S_WR_TEST: if (ack) state_d = S_RD_TEST;
      S_RD_TEST: if (ack) begin
        if (ack_rdata == DATA_W'(LINK_PATTERN)) state_d = S_RD_ID;
        else begin
          state_d   = S_FAIL;
          set_nodev = 1'b1;
        end
      end
      S_RD_ID: if (ack) begin
        state_d = S_RD_MODE;
        cap_id  = 1'b1;
      end
      S_RD_MODE: if (ack) begin
        cap_mode = 1'b1;
        if (mode_ok) state_d = S_RD_CTRL;
        else begin
          state_d    = S_FAIL;
          set_moderr = 1'b1;
        end
      end
      S_RD_CTRL: if (ack) begin
        state_d    = S_WR_CTRL;
        cap_shadow = 1'b1;
      end
      S_WR_CTRL: if (ack) begin
        state_d  = S_READY;
        set_done = 1'b1;
      end
      S_READY: if (en_cmd || dis_cmd) begin
        state_d = S_CMD_RD;
        cap_cmd = 1'b1;
      end
      S_CMD_RD: if (ack) begin
        state_d    = S_CMD_WR;
        cap_shadow = 1'b1;
      end
      S_CMD_WR: if (ack) state_d = S_READY;
      default: state_d = S_FAIL;
    endcase
  end

  // Request decode from state
  always_comb begin
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    unique case (state_q)
      S_WR_TEST: begin
        req_write = 1'b1;
        req_addr  = ADDR_W'(REG_TEST);
        req_wdata = DATA_W'(LINK_PATTERN);
      end
      S_RD_TEST: req_addr = ADDR_W'(REG_TEST);
      S_RD_ID:   req_addr = ADDR_W'(REG_ID);
      S_RD_MODE: req_addr = ADDR_W'(REG_MODE);
      S_RD_CTRL, S_CMD_RD: req_addr = ADDR_W'(REG_CTRL);
      S_WR_CTRL: begin
        req_write = 1'b1;
        req_addr  = ADDR_W'(REG_CTRL);
        req_wdata = shadow_q | SW_MASK;
      end
      S_CMD_WR: begin
        req_write = 1'b1;
        req_addr  = ADDR_W'(REG_CTRL);
        req_wdata = cmd_set_q ? (shadow_q | PWR_MASK) : (shadow_q & ~PWR_MASK);
      end
      default: req_valid = 1'b0;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rst_q     <= 1'b1;
      done_q    <= 1'b0;
      nodev_q   <= 1'b0;
      moderr_q  <= 1'b0;
      shadow_q  <= '0;
      cmd_set_q <= 1'b0;
      mode_q    <= '0;
      id_q      <= '0;
      ver_q     <= '0;
    end else begin
      state_q <= state_d;
      if (rel_rst)    rst_q    <= 1'b0;
      if (set_done)   done_q   <= 1'b1;
      if (set_nodev)  nodev_q  <= 1'b1;
      if (set_moderr) moderr_q <= 1'b1;
      if (cap_shadow) shadow_q <= ack_rdata;
      if (cap_cmd)    cmd_set_q <= en_cmd;
      if (cap_mode)   mode_q   <= mode_folded;
      if (cap_id) begin
        id_q  <= ack_rdata[2*NIB_W-1:NIB_W];
        ver_q <= ack_rdata[NIB_W-1:0];
      end
    end
  end

  assign chip_rst  = rst_q;
  assign done      = done_q;
  assign err_nodev = nodev_q;
  assign err_mode  = moderr_q;
  assign mode_code = mode_q;
  assign chip_id   = id_q;
  assign chip_ver  = ver_q;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETTLE_CYC = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              ack,
  input logic              chip_rst,
  input logic              done,
  input logic              err_nodev,
  input logic              err_mode
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 2);

  // Cycles since the chip reset was released, saturating
  logic [CW-1:0] since_rel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 since_rel_q <= '0;
    else if (chip_rst)                          since_rel_q <= '0;
    else if (since_rel_q < CW'(SETTLE_CYC))     since_rel_q <= since_rel_q + 1'b1;
  end

  a_r2_no_access_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !chip_rst);

  a_r2_settle_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (since_rel_q >= CW'(SETTLE_CYC)));

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ack) |=> (req_valid && $stable(req_write) && $stable(req_addr)
                             && $stable(req_wdata)));

  a_r3_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err_nodev || err_mode) |-> !req_valid);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r7_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_nodev, err_mode}));
endmodule

bind panel_bringup_seq pbs_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_pbs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .ack       (ack),
  .chip_rst  (chip_rst),
  .done      (done),
  .err_nodev (err_nodev),
  .err_mode  (err_mode)
);

// File: tb/tb_panel_bringup_seq.sv
module tb_panel_bringup_seq;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, en_cmd = 1'b0, dis_cmd = 1'b0;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic ack = 1'b0;
  logic [DW-1:0] ack_rdata = '0;
  logic chip_rst, done, err_nodev, err_mode;
  logic [2:0] mode_code;
  logic [3:0] chip_id, chip_ver;

  panel_bringup_seq #(.ADDR_W(AW), .DATA_W(DW), .MODE_W(3), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .ack_rdata(ack_rdata), .chip_rst(chip_rst),
    .done(done), .err_nodev(err_nodev), .err_mode(err_mode), .mode_code(mode_code),
    .chip_id(chip_id), .chip_ver(chip_ver)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [DW-1:0] regs [4];
  int  lat = 0;
  int  wait_cnt = 0;
  bit  bad_link = 0;
  int  req_cycles = 0;
  int  gap = 0;
  int  gap_seen = -1;
  int  cyc = 0;

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(bit wr, int addr, int data, string tag);
    exp_t e;
    e.wr = wr; e.addr = AW'(addr); e.data = DW'(data); e.tag = tag;
    q.push_back(e);
  endtask

  // Responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid) req_cycles++;
    if (rst_n && !chip_rst && gap_seen < 0) begin
      if (req_valid) gap_seen = gap;
      else gap++;
    end
    if (ack) begin
      ack = 1'b0;
    end else if (rst_n && req_valid) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        ack = 1'b1;
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected access: actual wr=%0d addr=%0d expected none",
                   req_write, req_addr);
        end else begin
          exp_t e;
          e = q.pop_front();
          check_eq(e.tag, "access kind", req_write, e.wr);
          check_eq(e.tag, "address", req_addr, e.addr);
          if (e.wr) check_eq(e.tag, "write data", req_wdata, e.data);
        end
        if (req_write) begin
          if (req_addr < 4) regs[req_addr[1:0]] = req_wdata;
        end else begin
          ack_rdata = (req_addr < 4) ? regs[req_addr[1:0]] : '0;
          if (bad_link && req_addr == 0) ack_rdata = ack_rdata ^ 8'h01;
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset(int id, int mode, int ctrl, int latency, bit bad);
    @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    regs[0] = 8'h00; regs[1] = DW'(id); regs[2] = DW'(mode); regs[3] = DW'(ctrl);
    lat = latency; bad_link = bad; wait_cnt = 0;
    repeat (3) @(negedge clk);
    req_cycles = 0; gap = 0; gap_seen = -1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic wait_outcome();
    for (int i = 0; i < 3000; i++) begin
      if (done || err_nodev || err_mode) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle_port();
    for (int i = 0; i < 500; i++) begin
      if (q.size() == 0 && !req_valid) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic push_detect(int ctrl, bit reach_ctrl);
    push_exp(1, 0, 8'h55, "R3 link write");
    push_exp(0, 0, 0, "R3 link read");
    push_exp(0, 1, 0, "R4 id read");
    push_exp(0, 2, 0, "R5 mode read");
    if (reach_ctrl) begin
      push_exp(0, 3, 0, "R7 ctrl read");
      push_exp(1, 3, ctrl | 8'h80, "R7 ctrl write");
    end
  endtask

  initial begin
    // R1: reset state
    do_reset(8'h3A, 8'h07, 8'h12, 0, 0);
    check_eq("R1", "chip_rst", chip_rst, 1);
    check_eq("R1", "req_valid", req_valid, 0);
    check_eq("R1", "done", done, 0);
    check_eq("R1", "errors", {err_nodev, err_mode}, 0);

    // R9: commands before bring-up do nothing
    pulse(en_cmd);
    pulse(dis_cmd);
    repeat (20) @(negedge clk);
    check_eq("R9", "requests before start", req_cycles, 0);
    check_eq("R9", "chip_rst before start", chip_rst, 1);

    // Normal bring-up, resolution code 7
    push_detect(8'h12, 1);
    pulse(start);
    check_eq("R2", "chip_rst after start", chip_rst, 0);
    wait_outcome();
    check_eq("R2", "settle cycles", gap_seen, SETTLE);
    check_eq("R7", "done", done, 1);
    check_eq("R4", "chip_id", chip_id, 4'h3);
    check_eq("R4", "chip_ver", chip_ver, 4'hA);
    check_eq("R5", "mode_code", mode_code, 7);
    check_eq("R7", "queue drained", q.size(), 0);
    check_eq("R9", "start ignored when ready", req_valid, 0);

    // R8: enable, disable, both at once
    push_exp(0, 3, 0, "R8 enable read");
    push_exp(1, 3, 8'h93, "R8 enable write");
    pulse(en_cmd);
    wait_idle_port();
    check_eq("R8", "enable drained", q.size(), 0);
    push_exp(0, 3, 0, "R8 disable read");
    push_exp(1, 3, 8'h92, "R8 disable write");
    pulse(dis_cmd);
    wait_idle_port();
    check_eq("R8", "disable drained", q.size(), 0);
    push_exp(0, 3, 0, "R8 both read");
    push_exp(1, 3, 8'h93, "R8 both write enable wins");
    en_cmd = 1'b1;
    dis_cmd = 1'b1;
    @(negedge clk);
    en_cmd = 1'b0;
    dis_cmd = 1'b0;
    wait_idle_port();
    check_eq("R8", "both drained", q.size(), 0);
    check_eq("R7", "done still high", done, 1);

    // R5/R10: dual-scan fold, noisy upper bits, slow responder
    do_reset(8'hC5, 8'hF9, 8'h00, 3, 0);
    push_detect(8'h00, 1);
    pulse(start);
    wait_outcome();
    check_eq("R5", "folded mode", mode_code, 5);
    check_eq("R10", "done with waits", done, 1);
    check_eq("R4", "chip_id slow", chip_id, 4'hC);

    // R6: code 0 is accepted, ctrl already owned
    do_reset(8'h11, 8'h00, 8'h81, 1, 0);
    push_detect(8'h81, 1);
    pulse(start);
    wait_outcome();
    check_eq("R6", "code 0 accepted", done, 1);
    check_eq("R6", "code 0 no err", err_mode, 0);

    // R6: code 3 rejected; R9: commands ignored after error
    do_reset(8'h22, 8'h03, 8'h00, 0, 0);
    push_detect(0, 0);
    pulse(start);
    wait_outcome();
    check_eq("R6", "err_mode code 3", err_mode, 1);
    check_eq("R6", "done low", done, 0);
    req_cycles = 0;
    pulse(en_cmd);
    pulse(start);
    repeat (20) @(negedge clk);
    check_eq("R9", "requests after error", req_cycles, 0);
    check_eq("R6", "queue drained", q.size(), 0);

    // R6: code 2 rejected
    do_reset(8'h22, 8'h02, 8'h00, 0, 0);
    push_detect(0, 0);
    pulse(start);
    wait_outcome();
    check_eq("R6", "err_mode code 2", err_mode, 1);

    // R3: link mismatch
    do_reset(8'h22, 8'h07, 8'h00, 2, 1);
    push_exp(1, 0, 8'h55, "R3 link write");
    push_exp(0, 0, 0, "R3 link read");
    pulse(start);
    wait_outcome();
    repeat (10) @(negedge clk);
    check_eq("R3", "err_nodev", err_nodev, 1);
    check_eq("R3", "no further access", q.size(), 0);
    check_eq("R3", "req_valid low", req_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule